// File: doc/BRIEF.md
# Supply Reset Sequencer with Chip-Enable Gating

This block turns digital supply-monitor decisions into the reset and power-status outputs of a processor supervisor. A supply-below-threshold indication or a held-low manual reset pin forces the active-low reset output low. Once every cause has cleared, a counter holds reset low for a fixed number of further clock cycles, so a bouncing pushbutton or a ragged supply ramp produces one clean reset. An early low-line warning and a battery-on flag are also produced. The battery-on flag moves to the battery only when the supply is both below the battery and below threshold. It moves back only when both conditions have cleared.

A chip-enable path lets an external memory select pass through while reset is inactive. When reset strikes during an access already in progress, the select stays asserted for a bounded grace window, or until the requester drops it, and is then blocked until reset has fully released. All monitor inputs and the manual reset pass through a synchronizer. The chip-enable output is gated combinationally from the raw chip-enable input, so the select path adds no clock latency.

Top module: `supply_reset_seq`

## Requirements
- R1: While `supply_low` is 1, `reset_n` is 0; `reset_n` falls SYNC_STAGES+1 cycles after `supply_low` rises.
- R2: With no other cause present, `reset_n` rises exactly SYNC_STAGES+STRETCH_CYC cycles after `supply_low` falls.
- R3: `man_rst_n`=0 forces `reset_n` to 0 with the same timing as R1 and R2. Any cause seen during the stretch restarts it, so release comes SYNC_STAGES+STRETCH_CYC cycles after the last cause clears. A single-cycle low pulse is enough to trigger it.
- R4: `lowline_n` equals the inverse of `supply_warn` delayed by SYNC_STAGES+1 cycles, regardless of the reset state.
- R5: `batt_on` becomes 1 SYNC_STAGES+1 cycles after `supply_low`=1 and `batt_above`=1 hold together.
- R6: `batt_on` becomes 0 SYNC_STAGES+1 cycles after `supply_low`=0 and `batt_above`=0 hold together; either mixed combination leaves it unchanged.
- R7: While `reset_n` is 1, `cs_out_n` equals `cs_in_n` in the same cycle.
- R8: If `cs_in_n` is 0 when reset asserts, `cs_out_n` stays 0 for exactly GRACE_CYC cycles after `reset_n` falls, then goes 1.
- R9: During the grace window a rise of `cs_in_n` drives `cs_out_n` to 1 at once. After SYNC_STAGES+1 cycles the gate is shut, and a later fall of `cs_in_n` leaves `cs_out_n` at 1.
- R10: If `cs_in_n` is 1 when reset asserts, `cs_out_n` stays 1 until `reset_n` rises, whatever `cs_in_n` does.
- R11: From the cycle `reset_n` rises, `cs_out_n` again follows `cs_in_n`.
- R12: While `rst_n` is 0: `reset_n`=0, `lowline_n`=0, `batt_on`=0, `cs_out_n`=1. After `rst_n` rises with clean inputs, `reset_n` rises SYNC_STAGES+STRETCH_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous logic reset, active low |
| supply_low | input | 1 | Supply is below the reset threshold |
| supply_warn | input | 1 | Supply is below the warning level (above threshold) |
| batt_above | input | 1 | Battery voltage is above the supply |
| man_rst_n | input | 1 | Manual reset request, active low |
| cs_in_n | input | 1 | Chip-enable request, active low |
| reset_n | output | 1 | Stretched reset, active low |
| lowline_n | output | 1 | Early low-supply warning, active low |
| batt_on | output | 1 | Output power taken from the battery |
| cs_out_n | output | 1 | Gated chip-enable, active low |

## Verification
Every monitor-driven output (`reset_n` falling, `lowline_n`, `batt_on`) is due SYNC_STAGES+1 cycles after its input changes. The bench checks one cycle early that nothing has moved yet, then checks the due cycle. A reset release is measured by counting cycles from the cause removal to the rise, and compared with SYNC_STAGES+STRETCH_CYC. The grace window is counted from the `reset_n` fall, and the same-cycle chip-enable paths are sampled 1 ns after the input change. Inputs change and outputs are sampled on the falling clock edge, so every count lands between rising edges.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    GATE_OPEN  = 2'd0,
    GATE_GRACE = 2'd1,
    GATE_SHUT  = 2'd2
  } gate_state_e;

  localparam int unsigned MON_BITS = 5;
  localparam int unsigned B_LOW    = 4;
  localparam int unsigned B_WARN   = 3;
  localparam int unsigned B_ABOVE  = 2;
  localparam int unsigned B_MR     = 1;
  localparam int unsigned B_CS     = 0;
  // Safe values on logic reset: supply low, warning on, no battery, no request.
  localparam logic [MON_BITS-1:0] MON_SAFE = 5'b11011;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rsq_stretch.sv
module rsq_stretch #(
  parameter int unsigned STRETCH_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause,
  output logic rst_active,
  output logic rst_set,
  output logic release_p
);
  localparam int unsigned CW = (STRETCH_CYC < 2) ? 1 : $clog2(STRETCH_CYC);
  localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

  logic [CW-1:0] cnt;

  assign rst_set   = cause & ~rst_active;
  assign release_p = rst_active & ~cause & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_active <= 1'b1;
      cnt        <= '0;
    end else if (cause) begin
      rst_active <= 1'b1;
      cnt        <= '0;
    end else if (rst_active) begin
      if (cnt == LAST) begin
        rst_active <= 1'b0;
        cnt        <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> (rst_active && cnt == '0));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |-> (cnt <= LAST));
  p_quiet_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active) |-> !$past(cause));
endmodule

// File: rtl/rsq_power_flags.sv
module rsq_power_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_s,
  input  logic low_s,
  input  logic above_s,
  output logic lowline_n,
  output logic batt_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowline_n <= 1'b0;
      batt_on   <= 1'b0;
    end else begin
      lowline_n <= ~warn_s;
      if (low_s && above_s)        batt_on <= 1'b1;
      else if (!low_s && !above_s) batt_on <= 1'b0;
    end
  end

  p_lowline_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warn_s |=> !lowline_n);
  p_batt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_s && above_s) |=> batt_on);
  p_batt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_s && !above_s) |=> !batt_on);
  p_batt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_s ^ above_s) |=> $stable(batt_on));
endmodule

// File: rtl/rsq_ce_gate.sv
module rsq_ce_gate
  import rsq_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 3750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_set,
  input  logic release_p,
  input  logic cs_s_n,
  input  logic cs_in_n,
  output logic cs_out_n,
  output logic in_grace
);
  localparam int unsigned GW = (GRACE_CYC < 2) ? 1 : $clog2(GRACE_CYC);
  localparam logic [GW-1:0] GLAST = GW'(GRACE_CYC - 1);

  gate_state_e   state;
  logic [GW-1:0] gcnt;
  logic          pass;

  assign in_grace = (state == GATE_GRACE);
  assign pass     = (state == GATE_OPEN) | in_grace;
  assign cs_out_n = cs_in_n | ~pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= GATE_SHUT;
      gcnt  <= '0;
    end else begin
      unique case (state)
        GATE_OPEN: begin
          gcnt <= '0;
          if (rst_set) state <= cs_s_n ? GATE_SHUT : GATE_GRACE;
        end
        GATE_GRACE: begin
          if (release_p) begin
            state <= GATE_OPEN;
            gcnt  <= '0;
          end else if (cs_s_n || gcnt == GLAST) begin
            state <= GATE_SHUT;
            gcnt  <= '0;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: begin
          gcnt <= '0;
          if (release_p) state <= GATE_OPEN;
        end
      endcase
    end
  end

  p_grace_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_grace |-> (gcnt <= GLAST));
  p_open_on_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    release_p |=> (state == GATE_OPEN));
  p_shut_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GATE_SHUT && !release_p) |=> (state == GATE_SHUT));
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import rsq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRETCH_CYC = 50_000_000,
  parameter int unsigned GRACE_CYC   = 3750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic supply_warn,
  input  logic batt_above,
  input  logic man_rst_n,
  input  logic cs_in_n,
  output logic reset_n,
  output logic lowline_n,
  output logic batt_on,
  output logic cs_out_n
);
  logic [MON_BITS-1:0] mon_raw, mon_s;
  logic cause_s, rst_active, rst_set, release_p, in_grace;

  assign mon_raw[B_LOW]   = supply_low;
  assign mon_raw[B_WARN]  = supply_warn;
  assign mon_raw[B_ABOVE] = batt_above;
  assign mon_raw[B_MR]    = man_rst_n;
  assign mon_raw[B_CS]    = cs_in_n;

  rsq_sync #(.WIDTH(MON_BITS), .STAGES(SYNC_STAGES), .RST_VAL(MON_SAFE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mon_raw), .q(mon_s)
  );

  assign cause_s = mon_s[B_LOW] | ~mon_s[B_MR];

  rsq_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk(clk), .rst_n(rst_n), .cause(cause_s),
    .rst_active(rst_active), .rst_set(rst_set), .release_p(release_p)
  );

  rsq_power_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .warn_s(mon_s[B_WARN]), .low_s(mon_s[B_LOW]), .above_s(mon_s[B_ABOVE]),
    .lowline_n(lowline_n), .batt_on(batt_on)
  );

  rsq_ce_gate #(.GRACE_CYC(GRACE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .rst_set(rst_set), .release_p(release_p),
    .cs_s_n(mon_s[B_CS]), .cs_in_n(cs_in_n),
    .cs_out_n(cs_out_n), .in_grace(in_grace)
  );

  assign reset_n = ~rst_active;

  p_reset_on_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cause_s |=> !reset_n);
  p_release_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n) |-> !$past(cause_s));
  p_cs_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_out_n |-> (reset_n || in_grace));
  p_cs_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_n |-> (cs_out_n == cs_in_n));
endmodule

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb;
  localparam int SYNC    = 2;
  localparam int STRETCH = 12;
  localparam int GRACE   = 6;

  logic clk = 1'b0;
  logic rst_n, supply_low, supply_warn, batt_above, man_rst_n, cs_in_n;
  logic reset_n, lowline_n, batt_on, cs_out_n;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  supply_reset_seq #(.SYNC_STAGES(SYNC), .STRETCH_CYC(STRETCH), .GRACE_CYC(GRACE)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .supply_warn(supply_warn),
    .batt_above(batt_above), .man_rst_n(man_rst_n), .cs_in_n(cs_in_n),
    .reset_n(reset_n), .lowline_n(lowline_n), .batt_on(batt_on), .cs_out_n(cs_out_n)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cycles_to_release(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!reset_n && k < 1000);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    rst_n = 1'b0; supply_low = 1'b0; supply_warn = 1'b0; batt_above = 1'b0;
    man_rst_n = 1'b1; cs_in_n = 1'b1;
    nclk(3);
    chk("R12 reset_n", reset_n, 0);
    chk("R12 lowline_n", lowline_n, 0);
    chk("R12 batt_on", batt_on, 0);
    chk("R12 cs_out_n", cs_out_n, 1);
    rst_n = 1'b1;
    cycles_to_release(k);
    chk("R12 first release", k, SYNC + STRETCH);
    chk("R4 lowline idle", lowline_n, 1);

    // R1/R2: supply_low held for several widths
    for (int w = SYNC + 1; w <= SYNC + 4; w++) begin
      supply_low = 1'b1;
      nclk(SYNC);
      chk("R1 not yet low", reset_n, 1);
      nclk(1);
      chk("R1 low", reset_n, 0);
      nclk(w - SYNC - 1);
      chk("R1 held", reset_n, 0);
      supply_low = 1'b0;
      cycles_to_release(k);
      chk("R2 stretch", k, SYNC + STRETCH);
    end

    // R3: manual reset and restart during stretch
    man_rst_n = 1'b0;
    nclk(SYNC);
    chk("R3 not yet low", reset_n, 1);
    nclk(1);
    chk("R3 low", reset_n, 0);
    nclk(2);
    man_rst_n = 1'b1;
    cycles_to_release(k);
    chk("R3 stretch", k, SYNC + STRETCH);
    man_rst_n = 1'b0;
    nclk(SYNC + 1);
    man_rst_n = 1'b1;
    nclk(STRETCH / 2);
    chk("R3 mid stretch", reset_n, 0);
    man_rst_n = 1'b0;
    nclk(1);
    man_rst_n = 1'b1;
    cycles_to_release(k);
    chk("R3 restart", k, SYNC + STRETCH);

    // R4: warning latency with reset idle and active
    for (int r = 0; r < 2; r++) begin
      if (r == 1) begin
        man_rst_n = 1'b0;
        nclk(SYNC + 1);
      end
      supply_warn = 1'b1;
      nclk(SYNC);
      chk("R4 not yet low", lowline_n, 1);
      nclk(1);
      chk("R4 low", lowline_n, 0);
      supply_warn = 1'b0;
      nclk(SYNC);
      chk("R4 not yet high", lowline_n, 0);
      nclk(1);
      chk("R4 high", lowline_n, 1);
      if (r == 1) begin
        man_rst_n = 1'b1;
        cycles_to_release(k);
      end
    end

    // R5/R6: every prior state against every input combination
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        int exp;
        supply_low = (p == 1); batt_above = (p == 1);
        nclk(SYNC + 1);
        chk("R5/R6 prior", batt_on, p);
        supply_low = c[1]; batt_above = c[0];
        exp = (c == 3) ? 1 : (c == 0) ? 0 : p;
        nclk(SYNC);
        chk("R5/R6 not yet", batt_on, p);
        nclk(1);
        if (c == 3)      chk("R5 set", batt_on, exp);
        else if (c == 0) chk("R6 clear", batt_on, exp);
        else             chk("R6 hold", batt_on, exp);
      end
    end
    supply_low = 1'b0; batt_above = 1'b0;
    cycles_to_release(k);
    chk("R2 after batt sweep", reset_n, 1);

    // R7: pass-through while reset idle
    for (int v = 0; v < 4; v++) begin
      cs_in_n = v[0];
      #1;
      chk("R7 follow", cs_out_n, v[0]);
      nclk(1);
    end

    // R8 then R10/R11: grace runs to its end
    cs_in_n = 1'b0;
    nclk(SYNC + 2);
    supply_low = 1'b1;
    nclk(SYNC + 1);
    chk("R1 low for R8", reset_n, 0);
    chk("R8 grace start", cs_out_n, 0);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!cs_out_n && k < 100);
    chk("R8 grace length", k, GRACE);
    nclk(3);
    chk("R10 blocked after grace", cs_out_n, 1);
    supply_low = 1'b0;
    k = 0;
    while (!reset_n) begin
      if (!cs_out_n) k++;
      @(negedge clk);
    end
    chk("R10 held through stretch", k, 0);
    chk("R11 reopen", cs_out_n, 0);

    // R9: requester ends early in grace
    supply_low = 1'b1;
    nclk(SYNC + 1);
    chk("R1 low for R9", reset_n, 0);
    nclk(1);
    cs_in_n = 1'b1;
    #1;
    chk("R9 immediate rise", cs_out_n, 1);
    nclk(SYNC + 2);
    cs_in_n = 1'b0;
    #1;
    chk("R9 stays shut", cs_out_n, 1);
    nclk(GRACE + 2);
    chk("R9 still shut", cs_out_n, 1);
    supply_low = 1'b0;
    cycles_to_release(k);
    chk("R11 reopen after R9", cs_out_n, 0);

    // R10: no access when reset strikes
    cs_in_n = 1'b1;
    nclk(SYNC + 2);
    supply_low = 1'b1;
    nclk(SYNC + 1);
    chk("R1 low for R10", reset_n, 0);
    cs_in_n = 1'b0;
    #1;
    chk("R10 blocked", cs_out_n, 1);
    nclk(GRACE + 3);
    chk("R10 still blocked", cs_out_n, 1);
    supply_low = 1'b0;
    cycles_to_release(k);
    chk("R2 release for R10", k, SYNC + STRETCH);
    chk("R11 reopen after R10", cs_out_n, 0);
    cs_in_n = 1'b1;
    #1;
    chk("R11 follows high", cs_out_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule